// File: doc/BRIEF.md
# Coalescing Store Write Buffer

This block sits between a core's committed-store stream and the next cache level. Each incoming store names a doubleword-aligned physical address, eight bytes of data and a byte-enable mask. The buffer gathers stores into 32-byte block entries. A later store to a block that already has an open entry is folded into that entry instead of taking a new slot. Entries leave one at a time over a valid/ready downstream port, each tagged with its entry number. An entry stays occupied until the next level returns a completion carrying that number.

Ordering is kept in two ways. First, once an entry has been handed downstream it takes no more bytes, and a later store to the same block opens a fresh entry that is held back until the older one completes. Second, a write-barrier pulse closes every entry present at that moment to further merging, and holds back every entry allocated afterwards until all the pre-barrier entries have completed.

Back-pressure rules: a store is taken on a cycle where `st_valid` and `st_ready` are both high. `st_ready` is combinational from `st_addr`, `bar_req` and `ds_ready` in the same cycle. The downstream side transfers on `ds_valid && ds_ready`. Once `ds_valid` is raised it stays high, with `ds_id` and `ds_blk` unchanged, until accepted. Stores merged into the offered entry in the meantime still appear in `ds_data`/`ds_mask`.

Top module: `store_merge_buffer`

## Requirements
- R1: After reset the buffer is empty: `ds_valid` is 0, `full` is 0 and `st_ready` is 1.
- R2: An accepted store writes byte b of `st_data` (bits 8b+7:8b) into block byte L*8+b when `st_be[b]` is 1, where L is address bits 4:3. Block byte n appears on `ds_data` bits 8n+7:8n with `ds_mask[n]` set. Bytes whose mask bit is clear carry no meaning.
- R3: A store to a block that has an entry still open for merging is folded into that entry without using a new one; newer bytes replace older bytes at the same position. At most one open entry exists per block.
- R4: At most one store is taken per cycle, on `st_valid && st_ready`.
- R5: An entry accepted downstream takes no further bytes. A later store to the same block gets a new entry, which is not offered until the earlier entry completes. A store arriving in the same cycle as the acceptance counts as later.
- R6: An entry is freed only by `cmp_valid` with `cmp_id` naming an entry already accepted downstream; a completion naming any other entry number changes nothing.
- R7: Among entries that may be offered, the one allocated earliest is offered first.
- R8: A `bar_req` pulse closes every entry present in that cycle to merging; a store taken in the barrier cycle is never merged into an existing entry.
- R9: An entry allocated in or after a barrier cycle is not offered until every entry present in that cycle has completed.
- R10: `full` is 1 exactly when all six entries are occupied and the presented store cannot merge; `st_ready` is then 0, while a mergeable store is still accepted with all entries occupied.
- R11: While `ds_valid` is 1 and `ds_ready` is 0, the next cycle keeps `ds_valid` at 1 with the same `ds_id` and `ds_blk`.
- R12: `ds_id` is an entry number below six that no other entry awaiting completion carries, and is the number the completion must return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Store presented |
| st_ready | output | 1 | Store can be taken this cycle |
| st_addr | input | 37 | Physical address bits 39:3 of the store doubleword |
| st_data | input | 64 | Store data, byte b in bits 8b+7:8b |
| st_be | input | 8 | Byte enables for `st_data` |
| bar_req | input | 1 | Write-barrier pulse |
| full | output | 1 | No free entry and the presented store cannot merge |
| ds_valid | output | 1 | Entry offered downstream |
| ds_ready | input | 1 | Downstream accepts the offered entry |
| ds_blk | output | 35 | Block address (physical address bits 39:5) |
| ds_data | output | 256 | Block data, byte n in bits 8n+7:8n |
| ds_mask | output | 32 | Byte-valid mask of the offered entry |
| ds_id | output | 3 | Entry number of the offered entry |
| cmp_valid | input | 1 | Downstream write completed |
| cmp_id | input | 3 | Entry number of the completed write |

## Verification
Random traffic confined to four block addresses makes merging, overlapping byte enables and same-block conflicts after dispatch frequent. Random `ds_ready` and completion timing separate the merge-until-accepted window and the held offer from eager closing or early freeing. Barriers sprinkled through that traffic distinguish correct fencing from plain same-block ordering. Directed runs fill all entries to separate a full buffer from a full-but-mergeable one. Stray completions for entries not yet sent must leave occupancy untouched. A barrier followed by the full drain must hold the post-barrier entry back while the older ones are still outstanding.

// File: rtl/smb_pkg.sv
package smb_pkg;
  typedef enum logic [1:0] {
    ENT_FREE = 2'd0,
    ENT_OPEN = 2'd1,
    ENT_SHUT = 2'd2,
    ENT_SENT = 2'd3
  } ent_state_e;
endpackage

// File: rtl/smb_low_pick.sv
module smb_low_pick #(
  parameter int N = 6,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          hit,
  output logic [IW-1:0] idx
);
  always_comb begin
    hit = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/smb_oldest_pick.sv
module smb_oldest_pick #(
  parameter int N = 6,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]        elig,
  input  logic [N-1:0][N-1:0] older,
  output logic                hit,
  output logic [IW-1:0]       idx
);
  logic [N-1:0] win;

  for (genvar g = 0; g < N; g++) begin : g_win
    assign win[g] = elig[g] && ((older[g] & elig) == '0);
  end

  smb_low_pick #(.N(N)) u_pick (.req(win), .hit(hit), .idx(idx));
endmodule

// File: rtl/smb_lane_merge.sv
module smb_lane_merge #(
  parameter int BLK_BYTES = 32,
  parameter int ST_BYTES  = 8,
  localparam int LANES  = BLK_BYTES / ST_BYTES,
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [BLK_BYTES*8-1:0] base_data,
  input  logic [BLK_BYTES-1:0]   base_mask,
  input  logic [LANE_W-1:0]      lane,
  input  logic [ST_BYTES*8-1:0]  wr_data,
  input  logic [ST_BYTES-1:0]    wr_be,
  output logic [BLK_BYTES*8-1:0] out_data,
  output logic [BLK_BYTES-1:0]   out_mask
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    for (genvar b = 0; b < ST_BYTES; b++) begin : g_byte
      localparam int P = l * ST_BYTES + b;
      logic take;
      assign take = (lane == LANE_W'(l)) && wr_be[b];
      assign out_data[P*8 +: 8] = take ? wr_data[b*8 +: 8] : base_data[P*8 +: 8];
      assign out_mask[P]        = take | base_mask[P];
    end
  end
endmodule

// File: rtl/store_merge_buffer.sv
module store_merge_buffer #(
  parameter int NUM_ENT   = 6,
  parameter int PA_W      = 40,
  parameter int BLK_BYTES = 32,
  parameter int ST_BYTES  = 8,
  localparam int BLK_OFF = $clog2(BLK_BYTES),
  localparam int ST_OFF  = $clog2(ST_BYTES),
  localparam int TAG_W   = PA_W - BLK_OFF,
  localparam int LANE_W  = BLK_OFF - ST_OFF,
  localparam int IDX_W   = $clog2(NUM_ENT)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   st_valid,
  output logic                   st_ready,
  input  logic [PA_W-1:ST_OFF]   st_addr,
  input  logic [ST_BYTES*8-1:0]  st_data,
  input  logic [ST_BYTES-1:0]    st_be,
  input  logic                   bar_req,
  output logic                   full,
  output logic                   ds_valid,
  input  logic                   ds_ready,
  output logic [TAG_W-1:0]       ds_blk,
  output logic [BLK_BYTES*8-1:0] ds_data,
  output logic [BLK_BYTES-1:0]   ds_mask,
  output logic [IDX_W-1:0]       ds_id,
  input  logic                   cmp_valid,
  input  logic [IDX_W-1:0]       cmp_id
);
  import smb_pkg::*;

  ent_state_e                   st_q   [NUM_ENT];
  logic [TAG_W-1:0]             tag_q  [NUM_ENT];
  logic [BLK_BYTES*8-1:0]       data_q [NUM_ENT];
  logic [BLK_BYTES-1:0]         mask_q [NUM_ENT];
  logic [NUM_ENT-1:0][NUM_ENT-1:0] dep_q, older_q;
  logic [NUM_ENT-1:0]           fence_q;
  logic                         lock_vld_q;
  logic [IDX_W-1:0]             lock_idx_q;

  logic [TAG_W-1:0]   st_tag;
  logic [LANE_W-1:0]  st_lane;
  logic [NUM_ENT-1:0] occ, blk_hit, open_hit, mrg_ok, elig, cmp_vec, fence_eff, alloc_dep;
  logic               pick_vld, merge_hit, free_hit, fire, acc, do_alloc;
  logic [IDX_W-1:0]   pick_idx, sel_idx, mrg_idx, free_idx;
  logic [BLK_BYTES*8-1:0] base_data, new_data;
  logic [BLK_BYTES-1:0]   base_mask, new_mask;

  assign st_tag  = st_addr[PA_W-1:BLK_OFF];
  assign st_lane = st_addr[BLK_OFF-1:ST_OFF];

  // Per-entry status vectors
  always_comb begin
    for (int i = 0; i < NUM_ENT; i++) begin
      occ[i]      = (st_q[i] != ENT_FREE);
      blk_hit[i]  = occ[i] && (tag_q[i] == st_tag);
      open_hit[i] = blk_hit[i] && (st_q[i] == ENT_OPEN);
      elig[i]     = ((st_q[i] == ENT_OPEN) || (st_q[i] == ENT_SHUT)) && (dep_q[i] == '0);
      cmp_vec[i]  = cmp_valid && (cmp_id == IDX_W'(i)) && (st_q[i] == ENT_SENT);
    end
  end

  // Downstream offer: a held offer wins over a fresh pick
  smb_oldest_pick #(.N(NUM_ENT)) u_oldest (
    .elig(elig), .older(older_q), .hit(pick_vld), .idx(pick_idx)
  );

  assign sel_idx  = lock_vld_q ? lock_idx_q : pick_idx;
  assign ds_valid = lock_vld_q | pick_vld;
  assign fire     = ds_valid && ds_ready;
  assign ds_id    = sel_idx;
  assign ds_blk   = tag_q[sel_idx];
  assign ds_data  = data_q[sel_idx];
  assign ds_mask  = mask_q[sel_idx];

  // Merge target: open, same block, no barrier now, not leaving this cycle
  always_comb begin
    for (int i = 0; i < NUM_ENT; i++) begin
      mrg_ok[i] = open_hit[i] && !bar_req && !(fire && (sel_idx == IDX_W'(i)));
    end
  end

  smb_low_pick #(.N(NUM_ENT)) u_mrg  (.req(mrg_ok), .hit(merge_hit), .idx(mrg_idx));
  smb_low_pick #(.N(NUM_ENT)) u_free (.req(~occ),   .hit(free_hit),  .idx(free_idx));

  assign full      = !free_hit && !merge_hit;
  assign st_ready  = !full;
  assign acc       = st_valid && st_ready;
  assign do_alloc  = acc && !merge_hit;
  assign fence_eff = bar_req ? occ : fence_q;
  assign alloc_dep = (blk_hit | fence_eff) & ~cmp_vec;

  assign base_data = merge_hit ? data_q[mrg_idx] : '0;
  assign base_mask = merge_hit ? mask_q[mrg_idx] : '0;

  smb_lane_merge #(.BLK_BYTES(BLK_BYTES), .ST_BYTES(ST_BYTES)) u_merge (
    .base_data(base_data), .base_mask(base_mask), .lane(st_lane),
    .wr_data(st_data), .wr_be(st_be), .out_data(new_data), .out_mask(new_mask)
  );

  // Control state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_ENT; i++) begin
        st_q[i]    <= ENT_FREE;
        dep_q[i]   <= '0;
        older_q[i] <= '0;
      end
      fence_q    <= '0;
      lock_vld_q <= 1'b0;
      lock_idx_q <= '0;
    end else begin
      for (int i = 0; i < NUM_ENT; i++) begin
        if (cmp_vec[i])                                   st_q[i] <= ENT_FREE;
        else if (fire && (sel_idx == IDX_W'(i)))          st_q[i] <= ENT_SENT;
        else if (do_alloc && (free_idx == IDX_W'(i)))     st_q[i] <= ENT_OPEN;
        else if (bar_req && (st_q[i] == ENT_OPEN))        st_q[i] <= ENT_SHUT;
        if (do_alloc && (free_idx == IDX_W'(i))) begin
          dep_q[i]   <= alloc_dep;
          older_q[i] <= occ & ~cmp_vec;
        end else begin
          dep_q[i]   <= dep_q[i] & ~cmp_vec;
          older_q[i] <= older_q[i] & ~cmp_vec;
        end
      end
      fence_q    <= fence_eff & ~cmp_vec;
      lock_vld_q <= ds_valid && !ds_ready;
      lock_idx_q <= sel_idx;
    end
  end

  // Payload storage
  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_ENT; i++) begin
      if (acc && ((merge_hit && (mrg_idx == IDX_W'(i))) || (do_alloc && (free_idx == IDX_W'(i))))) begin
        data_q[i] <= new_data;
        mask_q[i] <= new_mask;
      end
      if (do_alloc && (free_idx == IDX_W'(i))) tag_q[i] <= st_tag;
    end
  end

  AST_OFFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ds_valid && !ds_ready |=> ds_valid && $stable(ds_id) && $stable(ds_blk)); // R11
  AST_NO_EARLY_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
    ds_valid |-> (dep_q[ds_id] == '0)); // R9
  AST_ONE_OPEN_PER_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(open_hit) <= 1); // R3

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_chk
    AST_SENT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q[g] == ENT_SENT) |=> (st_q[g] == ENT_FREE) || $stable(mask_q[g])); // R5
    AST_FREE_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q[g] != ENT_FREE) && !(cmp_valid && (cmp_id == IDX_W'(g))) |=> (st_q[g] != ENT_FREE)); // R6
  end
endmodule

// File: tb/store_merge_buffer_tb_top.sv
module store_merge_buffer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 6;
  localparam int PA_W = 40;
  localparam int TAG_W = 35;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic st_valid = 1'b0, st_ready, bar_req = 1'b0, full;
  logic [PA_W-1:3] st_addr = '0;
  logic [63:0] st_data = '0;
  logic [7:0] st_be = '0;
  logic ds_valid, ds_ready = 1'b0;
  logic [TAG_W-1:0] ds_blk;
  logic [255:0] ds_data;
  logic [31:0] ds_mask;
  logic [2:0] ds_id, cmp_id = '0;
  logic cmp_valid = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  store_merge_buffer dut_i (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
    .st_addr(st_addr), .st_data(st_data), .st_be(st_be), .bar_req(bar_req),
    .full(full), .ds_valid(ds_valid), .ds_ready(ds_ready), .ds_blk(ds_blk),
    .ds_data(ds_data), .ds_mask(ds_mask), .ds_id(ds_id),
    .cmp_valid(cmp_valid), .cmp_id(cmp_id)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // Reference model, slots unrelated to design entry numbers
  bit m_used[N], m_sent[N], m_open[N];
  logic [TAG_W-1:0] m_tag[N];
  logic [255:0] m_data[N];
  logic [31:0] m_mask[N];
  logic [N-1:0] m_dep[N];
  logic [N-1:0] m_fence;
  int m_age[N];
  int m_offer, m_serial;
  logic [2:0] m_offer_id;
  int id2slot[8];

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (ok !== 1'b1) begin
      n_bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [255:0] expand(input logic [31:0] m);
    logic [255:0] r;
    for (int n = 0; n < 32; n++) r[n*8 +: 8] = {8{m[n]}};
    return r;
  endfunction

  function automatic int oldest();
    int best = -1;
    for (int j = 0; j < N; j++)
      if (m_used[j] && !m_sent[j] && m_dep[j] == '0 && (best < 0 || m_age[j] < m_age[best])) best = j;
    return best;
  endfunction

  function automatic int pick_sent(input int start);
    for (int k = 0; k < 8; k++) if (id2slot[(start + k) % 8] >= 0) return (start + k) % 8;
    return -1;
  endfunction

  function automatic logic [PA_W-1:3] mk_addr(input int tag, input int lane);
    return {TAG_W'(tag), 2'(lane)};
  endfunction

  task automatic model_clear();
    for (int j = 0; j < N; j++) begin
      m_used[j] = 0; m_sent[j] = 0; m_open[j] = 0; m_dep[j] = '0; m_mask[j] = '0; m_data[j] = '0;
    end
    for (int k = 0; k < 8; k++) id2slot[k] = -1;
    m_fence = '0; m_offer = -1; m_serial = 0;
  endtask

  task automatic do_reset();
    st_valid = 0; bar_req = 0; ds_ready = 0; cmp_valid = 0;
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    model_clear();
    @(negedge clk);
  endtask

  // One cycle: drive at negedge, compare, advance model, reach next negedge
  task automatic step(input logic sv, input logic [PA_W-1:3] a, input logic [63:0] d,
                      input logic [7:0] be, input logic bar, input logic rdy,
                      input logic cv, input logic [2:0] cid);
    int off, tgt, nocc, cslot, f, ln;
    logic [TAG_W-1:0] t;
    logic [N-1:0] used_pre, fence_eff, ndep;
    logic exp_full;
    logic [255:0] em;
    st_valid = sv; st_addr = a; st_data = d; st_be = be; bar_req = bar;
    ds_ready = rdy; cmp_valid = cv; cmp_id = cid;
    #1;
    t = a[PA_W-1:5]; ln = int'(a[4:3]);
    off = m_offer;
    if (off < 0) off = oldest();
    chk(ds_valid == (off >= 0), "R7 R9 R5", "ds_valid", 256'(ds_valid), 256'(off >= 0));
    if (m_offer >= 0) chk(ds_id == m_offer_id, "R11", "held ds_id", 256'(ds_id), 256'(m_offer_id));
    if (off >= 0 && ds_valid) begin
      em = expand(m_mask[off]);
      chk(ds_blk == m_tag[off], "R7 R5", "ds_blk", 256'(ds_blk), 256'(m_tag[off]));
      chk(ds_mask == m_mask[off], "R2 R3", "ds_mask", 256'(ds_mask), 256'(m_mask[off]));
      chk((ds_data & em) == (m_data[off] & em), "R2 R3", "ds_data", ds_data & em, m_data[off] & em);
    end
    tgt = -1; nocc = 0;
    for (int j = 0; j < N; j++) begin
      used_pre[j] = m_used[j];
      if (m_used[j]) nocc++;
      if (m_used[j] && m_open[j] && m_tag[j] == t && !bar && !(j == off && rdy)) tgt = j;
    end
    exp_full = (nocc == N) && (tgt < 0);
    chk(full == exp_full, "R10", "full", 256'(full), 256'(exp_full));
    chk(st_ready == !exp_full, "R4 R10", "st_ready", 256'(st_ready), 256'(!exp_full));
    cslot = (cv && id2slot[cid] >= 0) ? id2slot[cid] : -1;
    fence_eff = bar ? used_pre : m_fence;
    if (off >= 0 && rdy) begin
      chk(ds_id < 3'd6 && id2slot[ds_id] < 0, "R12", "ds_id in use", 256'(ds_id), 256'(0));
      m_sent[off] = 1; m_open[off] = 0; id2slot[ds_id] = off; m_offer = -1;
    end else if (off >= 0) begin
      m_offer = off; m_offer_id = ds_id;
    end else m_offer = -1;
    if (bar) for (int j = 0; j < N; j++) if (used_pre[j]) m_open[j] = 0;
    if (sv && !exp_full) begin
      f = tgt;
      if (f < 0) begin
        for (int j = N - 1; j >= 0; j--) if (!used_pre[j]) f = j;
        ndep = '0;
        for (int j = 0; j < N; j++) if (used_pre[j] && (m_tag[j] == t || fence_eff[j]) && j != cslot) ndep[j] = 1;
        m_used[f] = 1; m_open[f] = 1; m_sent[f] = 0; m_tag[f] = t; m_mask[f] = '0;
        m_data[f] = '0; m_dep[f] = ndep; m_age[f] = m_serial++;
      end
      for (int b = 0; b < 8; b++) if (be[b]) begin
        m_data[f][(ln*8 + b)*8 +: 8] = d[b*8 +: 8];
        m_mask[f][ln*8 + b] = 1;
      end
    end
    if (cslot >= 0) begin
      m_used[cslot] = 0; m_sent[cslot] = 0; id2slot[cid] = -1;
      for (int j = 0; j < N; j++) m_dep[j][cslot] = 0;
      fence_eff[cslot] = 0;
    end
    m_fence = fence_eff;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic st1(input int tag, input int lane, input logic rdy);
    step(1, mk_addr(tag, lane), {$urandom, $urandom}, 8'($urandom), 0, rdy, 0, 0);
  endtask

  task automatic idle(input logic rdy, input logic cv, input logic [2:0] cid);
    step(0, '0, '0, '0, 0, rdy, cv, cid);
  endtask

  task automatic peek_full(input int tag, input logic exp, input string req);
    st_valid = 0; st_addr = mk_addr(tag, 0); bar_req = 0; ds_ready = 0; cmp_valid = 0;
    #1;
    chk(full == exp, req, "full peek", 256'(full), 256'(exp));
  endtask

  task automatic drain();
    int id;
    for (int k = 0; k < 400; k++) begin
      id = pick_sent(0);
      idle(1, id >= 0, 3'(id < 0 ? 0 : id));
    end
    for (int j = 0; j < N; j++) chk(!m_used[j], "R6", "model not drained", 256'(j), 256'(0));
  endtask

  initial begin
    int id;
    void'($urandom(32'd4242));
    model_clear();
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    #1;
    chk(ds_valid == 0, "R1", "ds_valid", 256'(ds_valid), 0);
    chk(full == 0, "R1", "full", 256'(full), 0);
    chk(st_ready == 1, "R1", "st_ready", 256'(st_ready), 1);
    @(negedge clk);

    // R10: fill every entry, then full vs mergeable
    for (int k = 0; k < N; k++) st1(k, k % 4, 0);
    peek_full(9, 1, "R10");
    peek_full(2, 0, "R10 merge");
    step(1, mk_addr(2, 1), 64'h1122334455667788, 8'hff, 0, 0, 0, 0);
    // R6: completions for entries never sent are ignored
    for (int k = 0; k < N; k++) idle(0, 1, 3'(k));
    peek_full(9, 1, "R6");
    drain();

    // R5: same-block store during dispatch opens a held entry
    do_reset();
    step(1, mk_addr(5, 0), 64'hAAAA, 8'h0f, 0, 1, 0, 0);
    step(1, mk_addr(5, 0), 64'hBBBB, 8'hf0, 0, 1, 0, 0);
    for (int k = 0; k < 3; k++) idle(1, 0, 0);
    #1 chk(ds_valid == 0, "R5", "second entry offered early", 256'(ds_valid), 0);
    drain();

    // R8 and R9: barrier closes merging and fences later entries
    do_reset();
    for (int k = 1; k <= 5; k++) st1(k, 0, 0);
    step(0, '0, '0, '0, 1, 0, 0, 0);
    peek_full(2, 0, "R8");
    st1(2, 3, 0);
    peek_full(3, 1, "R8");
    for (int k = 0; k < 7; k++) idle(1, 0, 0);
    #1 chk(ds_valid == 0, "R9", "post-barrier entry offered", 256'(ds_valid), 0);
    drain();

    // Random mix
    do_reset();
    for (int k = 0; k < 5000; k++) begin
      id = pick_sent(int'($urandom % 8));
      if ($urandom % 10 == 0) id = int'($urandom % 8);
      step(($urandom % 10) < 7, mk_addr(int'($urandom % 4), int'($urandom % 4)),
           {$urandom, $urandom}, 8'($urandom), ($urandom % 25) == 0,
           ($urandom % 10) < 6, (id >= 0) && (($urandom % 10) < 3), 3'(id < 0 ? 0 : id));
    end
    drain();

    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R4 watchdog expired act=running exp=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule